// File: doc/BRIEF.md
# Modem Control-Line Handler

This block is the control logic on the modem side for the four serial-port control lines: two requests coming from the terminal (request-to-send and terminal-ready) and two replies going back (clear-to-send and set-ready). It also drives a carrier-detect output and a lock indicator. A registered mode input selects how the lines are used.

With the mode input low, the two request lines are treated as slow data channels. A free-running divider samples them once every 1536 clock cycles. The sampled pair is handed to the link with a one-cycle strobe. Values received from the far end then drive the reply lines. When any loopback is selected, the local samples drive the reply lines instead. With the mode input high, the lines follow terminal/modem handshake rules. Set-ready is held active. Clear-to-send answers request-to-send only while the link is locked. Carrier detect depends on lock, terminal-ready and the diagnostic selection.

All request, lock and selection inputs pass through a two-flop synchroniser. Every reply output is registered. All control lines are active low.

Top module: `modem_ctl`

## Requirements
- R1: The sample strobe `smp_stb_o` pulses for exactly one cycle once every 1536 cycles (parameter `DIV`). On each pulse, `smp_ch_o[0]` carries the synchronised request-to-send level and `smp_ch_o[1]` carries the synchronised terminal-ready level.
- R2: In data-channel mode (`hs_mode_i`=0) with diagnostic selection 2'b00 (normal), `far_ch_i` is captured when `far_vld_i` is high. Bit 0 of the captured value drives `cts_n_o` and bit 1 drives `dsr_n_o`. `far_ch_i` has no effect while `far_vld_i` is low.
- R3: In data-channel mode with any loopback selected (2'b01 local, 2'b10 remote initiator, 2'b11 remote responder), the last local sample drives the reply lines: bit 0 to `cts_n_o` and bit 1 to `dsr_n_o`. `far_ch_i` has no effect in this case.
- R4: In handshake mode, `dsr_n_o` is low (active).
- R5: In handshake mode, `cts_n_o` is low only while the link is locked and `rts_n_i` is low. It is high on loss of lock or when `rts_n_i` is high.
- R6: Under normal selection or remote-initiator selection, `dcd_n_o` is low only while the link is locked. In handshake mode it additionally requires `dtr_n_i` low; with `dtr_n_i` high it is forced high.
- R7: Under local loopback or remote-responder selection, `dcd_n_o` is high in both modes.
- R8: `lock_o` equals the synchronised `lock_i` in every mode and selection, independent of request lines.
- R9: While `rst` is high, `cts_n_o`, `dsr_n_o` and `dcd_n_o` are high, and `lock_o` and `smp_stb_o` are low.
- R10: A change on `rts_n_i`, `dtr_n_i`, `lock_i`, `hs_mode_i` or `diag_i` reaches the handshake outputs and `lock_o` on the third rising edge after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| hs_mode_i | input | 1 | 0 = data-channel use, 1 = handshake use |
| rts_n_i | input | 1 | Request to send from terminal, active low |
| dtr_n_i | input | 1 | Terminal ready, active low |
| lock_i | input | 1 | Link synchronisation status from lock detector |
| diag_i | input | 2 | Diagnostic selection: 00 normal, 01 local loop, 10 remote initiator, 11 remote responder |
| far_ch_i | input | 2 | Channel pair received from far end (bit 0 to CTS, bit 1 to DSR) |
| far_vld_i | input | 1 | One-cycle valid for `far_ch_i` |
| smp_ch_o | output | 2 | Sampled request pair sent to the link |
| smp_stb_o | output | 1 | One-cycle strobe marking a new sample |
| cts_n_o | output | 1 | Clear to send, active low |
| dsr_n_o | output | 1 | Set ready, active low |
| dcd_n_o | output | 1 | Carrier detect, active low |
| lock_o | output | 1 | Lock indicator, high when locked |

## Verification
The handshake outputs and the lock indicator are due three rising edges after an input change: two synchroniser stages and one output register. The bench drives inputs on falling edges and reads the outputs on the fourth falling edge that follows. A far-end value with its valid pulse appears two edges later. A loopback sample appears one edge after the strobe that captured it. The bench therefore waits for the strobe at a falling edge and reads one falling edge later. The strobe period is measured by counting edges between two pulses.

// File: rtl/mctl_pkg.sv
package mctl_pkg;

    typedef enum logic [1:0] {
        DG_NORMAL = 2'b00,
        DG_LOCAL  = 2'b01,
        DG_R_INIT = 2'b10,
        DG_R_RESP = 2'b11
    } diag_e;

    typedef struct packed {
        logic  hs_mode;
        logic  lock;
        diag_e diag;
        logic  dtr_n;
        logic  rts_n;
    } ctl_s;

    localparam int CTL_W = $bits(ctl_s);
    localparam logic [CTL_W-1:0] CTL_RST = 6'b00_0011;

    typedef struct packed {
        logic cts_n;
        logic dsr_n;
        logic dcd_n;
        logic lock;
    } reply_s;

    localparam reply_s REPLY_RST = '{cts_n: 1'b1, dsr_n: 1'b1, dcd_n: 1'b1, lock: 1'b0};

    function automatic logic diag_kills_dcd(diag_e d);
        return (d == DG_LOCAL) || (d == DG_R_RESP);
    endfunction

    function automatic logic carrier_n(ctl_s c);
        logic up;
        up = c.lock && (!c.hs_mode || !c.dtr_n);
        return diag_kills_dcd(c.diag) ? 1'b1 : !up;
    endfunction

endpackage

// File: rtl/mctl_sync.sv
module mctl_sync #(
    parameter int              WIDTH   = 6,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    stg[s] <= RST_VAL;
                else if (s == 0)
                    stg[s] <= d_i;
                else
                    stg[s] <= stg[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/mctl_sampler.sv
module mctl_sampler #(
    parameter int DIV = 1536
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rts_n,
    input  logic       dtr_n,
    output logic       stb_o,
    output logic [1:0] ch_o
);
    localparam int CNT_W = $clog2(DIV);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             hit;

    assign hit = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            stb_o <= 1'b0;
            ch_o  <= 2'b11;
        end else begin
            cnt_q <= hit ? '0 : cnt_q + 1'b1;
            stb_o <= hit;
            if (hit)
                ch_o <= {dtr_n, rts_n};
        end
    end
endmodule

// File: rtl/mctl_rules.sv
module mctl_rules
    import mctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  ctl_s       ctl,
    input  logic [1:0] loc_ch,
    input  logic [1:0] far_ch,
    input  logic       far_vld,
    output reply_s     rep_o
);
    logic [1:0] far_q;
    reply_s     nxt;

    always_ff @(posedge clk) begin
        if (rst)
            far_q <= 2'b11;
        else if (far_vld)
            far_q <= far_ch;
    end

    always_comb begin
        nxt.lock  = ctl.lock;
        nxt.dcd_n = carrier_n(ctl);
        if (ctl.hs_mode) begin
            nxt.dsr_n = 1'b0;
            nxt.cts_n = !(ctl.lock && !ctl.rts_n);
        end else if (ctl.diag != DG_NORMAL) begin
            nxt.cts_n = loc_ch[0];
            nxt.dsr_n = loc_ch[1];
        end else begin
            nxt.cts_n = far_q[0];
            nxt.dsr_n = far_q[1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rep_o <= REPLY_RST;
        else
            rep_o <= nxt;
    end
endmodule

// File: rtl/modem_ctl.sv
module modem_ctl
    import mctl_pkg::*;
#(
    parameter int DIV = 1536
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hs_mode_i,
    input  logic       rts_n_i,
    input  logic       dtr_n_i,
    input  logic       lock_i,
    input  logic [1:0] diag_i,
    input  logic [1:0] far_ch_i,
    input  logic       far_vld_i,
    output logic [1:0] smp_ch_o,
    output logic       smp_stb_o,
    output logic       cts_n_o,
    output logic       dsr_n_o,
    output logic       dcd_n_o,
    output logic       lock_o
);
    ctl_s   ctl_raw;
    ctl_s   ctl_q;
    reply_s rep;

    always_comb begin
        ctl_raw.hs_mode = hs_mode_i;
        ctl_raw.lock    = lock_i;
        ctl_raw.diag    = diag_e'(diag_i);
        ctl_raw.dtr_n   = dtr_n_i;
        ctl_raw.rts_n   = rts_n_i;
    end

    mctl_sync #(.WIDTH(CTL_W), .STAGES(2), .RST_VAL(CTL_RST)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (ctl_raw),
        .q_o (ctl_q)
    );

    mctl_sampler #(.DIV(DIV)) u_smp (
        .clk   (clk),
        .rst   (rst),
        .rts_n (ctl_q.rts_n),
        .dtr_n (ctl_q.dtr_n),
        .stb_o (smp_stb_o),
        .ch_o  (smp_ch_o)
    );

    mctl_rules u_rules (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl_q),
        .loc_ch  (smp_ch_o),
        .far_ch  (far_ch_i),
        .far_vld (far_vld_i),
        .rep_o   (rep)
    );

    assign cts_n_o = rep.cts_n;
    assign dsr_n_o = rep.dsr_n;
    assign dcd_n_o = rep.dcd_n;
    assign lock_o  = rep.lock;
endmodule

// File: rtl/mctl_checker.sv
module mctl_checker
    import mctl_pkg::*;
#(
    parameter int DIV = 1536
) (
    input logic clk,
    input logic rst,
    input ctl_s ctl_q,
    input logic smp_stb_o,
    input logic cts_n_o,
    input logic dsr_n_o,
    input logic dcd_n_o,
    input logic lock_o
);
    localparam int GW = $clog2(DIV) + 1;

    logic          seen_q;
    logic [GW-1:0] gap_q;
    logic          mode_q, lock_q, dtr_q;
    diag_e         diag_q;

    assign mode_q = ctl_q.hs_mode;
    assign lock_q = ctl_q.lock;
    assign dtr_q  = ctl_q.dtr_n;
    assign diag_q = ctl_q.diag;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b0;
            gap_q  <= '0;
        end else if (smp_stb_o) begin
            seen_q <= 1'b1;
            gap_q  <= '0;
        end else begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    p_stb_single_r1: assert property (@(posedge clk) disable iff (rst)
        smp_stb_o |=> !smp_stb_o);

    p_stb_period_r1: assert property (@(posedge clk) disable iff (rst)
        (smp_stb_o && seen_q) |-> (gap_q == GW'(DIV - 1)));

    p_dsr_active_r4: assert property (@(posedge clk) disable iff (rst)
        mode_q |=> !dsr_n_o);

    p_cts_needs_lock_r5: assert property (@(posedge clk) disable iff (rst)
        (mode_q && !lock_q) |=> cts_n_o);

    p_dtr_gate_r6: assert property (@(posedge clk) disable iff (rst)
        (mode_q && dtr_q) |=> dcd_n_o);

    p_loop_dcd_r7: assert property (@(posedge clk) disable iff (rst)
        (diag_q == DG_LOCAL || diag_q == DG_R_RESP) |=> dcd_n_o);

    p_lock_follow_r8: assert property (@(posedge clk) disable iff (rst)
        lock_o == $past(lock_q));

    p_reset_idle_r9: assert property (@(posedge clk)
        $past(rst) |-> (cts_n_o && dsr_n_o && dcd_n_o && !lock_o));
endmodule

bind modem_ctl mctl_checker #(.DIV(DIV)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctl_q     (ctl_q),
    .smp_stb_o (smp_stb_o),
    .cts_n_o   (cts_n_o),
    .dsr_n_o   (dsr_n_o),
    .dcd_n_o   (dcd_n_o),
    .lock_o    (lock_o)
);

// File: tb/test_modem_ctl.sv
module test_modem_ctl;
    localparam int DIV = 1536;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hs_mode_i = 1'b0;
    logic       rts_n_i = 1'b1;
    logic       dtr_n_i = 1'b1;
    logic       lock_i = 1'b0;
    logic [1:0] diag_i = 2'b00;
    logic [1:0] far_ch_i = 2'b11;
    logic       far_vld_i = 1'b0;
    logic [1:0] smp_ch_o;
    logic       smp_stb_o;
    logic       cts_n_o, dsr_n_o, dcd_n_o, lock_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    modem_ctl #(.DIV(DIV)) i_modem_ctl (
        .clk (clk), .rst (rst), .hs_mode_i (hs_mode_i), .rts_n_i (rts_n_i),
        .dtr_n_i (dtr_n_i), .lock_i (lock_i), .diag_i (diag_i),
        .far_ch_i (far_ch_i), .far_vld_i (far_vld_i), .smp_ch_o (smp_ch_o),
        .smp_stb_o (smp_stb_o), .cts_n_o (cts_n_o), .dsr_n_o (dsr_n_o),
        .dcd_n_o (dcd_n_o), .lock_o (lock_o)
    );

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%b exp=%b", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic far_push(input logic [1:0] v);
        far_ch_i  = v;
        far_vld_i = 1'b1;
        @(negedge clk);
        far_vld_i = 1'b0;
        far_ch_i  = ~v;
        @(negedge clk);
    endtask

    task automatic wait_stb();
        @(negedge clk);
        while (!smp_stb_o) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int t0;
        int per;
        logic exp_dcd;
        logic exp_cts;
        logic [1:0] v;

        repeat (5) @(negedge clk);
        // R9: reset state
        chk("R9", {cts_n_o, dsr_n_o, dcd_n_o, lock_o}, 4'b1110);
        chk("R9 strobe", {3'b000, smp_stb_o}, 4'b0000);
        rst = 1'b0;

        // R1: strobe period and single-cycle width
        wait_stb();
        chk("R1 width", {3'b000, smp_stb_o}, 4'b0001);
        @(negedge clk);
        chk("R1 width", {3'b000, smp_stb_o}, 4'b0000);
        t0 = 1;
        while (!smp_stb_o) begin @(negedge clk); t0++; end
        per = t0;
        chk("R1 period", per[3:0], 4'(DIV));
        total++;
        if (per != DIV) begin bad++; $display("FAIL R1 act=%0d exp=%0d", per, DIV); end

        // R1: sampled pair content
        for (int k = 0; k < 4; k++) begin
            rts_n_i = k[0];
            dtr_n_i = k[1];
            settle();
            wait_stb();
            chk("R1 content", {2'b00, smp_ch_o}, {2'b00, k[1], k[0]});
        end

        // R2: far-end channels in normal data mode
        diag_i = 2'b00;
        lock_i = 1'b1;
        settle();
        for (int k = 0; k < 4; k++) begin
            v = 2'(k);
            far_push(v);
            chk("R2 far", {2'b00, dsr_n_o, cts_n_o}, {2'b00, v});
            far_ch_i = ~v;
            repeat (3) @(negedge clk);
            chk("R2 no valid", {2'b00, dsr_n_o, cts_n_o}, {2'b00, v});
            chk("R6 data dcd", {3'b000, dcd_n_o}, 4'b0000);
        end

        // R3: loopback returns local samples, far input ignored
        for (int d = 1; d < 4; d++) begin
            diag_i = 2'(d);
            for (int k = 0; k < 4; k++) begin
                rts_n_i = k[0];
                dtr_n_i = k[1];
                settle();
                wait_stb();
                far_push({~k[1], ~k[0]});
                chk("R3 loop", {2'b00, dsr_n_o, cts_n_o}, {2'b00, k[1], k[0]});
                exp_dcd = (d == 2) ? 1'b0 : 1'b1;
                chk("R7/R6 data dcd", {3'b000, dcd_n_o}, {3'b000, exp_dcd});
            end
        end

        // R4 R5 R6 R7 R8: exhaustive handshake sweep
        hs_mode_i = 1'b1;
        for (int m = 0; m < 32; m++) begin
            lock_i  = m[0];
            rts_n_i = m[1];
            dtr_n_i = m[2];
            diag_i  = 2'(m >> 3);
            settle();
            exp_cts = !(m[0] && !m[1]);
            if (diag_i == 2'b01 || diag_i == 2'b11) exp_dcd = 1'b1;
            else exp_dcd = !(m[0] && !m[2]);
            chk("R4 dsr", {3'b000, dsr_n_o}, 4'b0000);
            chk("R5 cts", {3'b000, cts_n_o}, {3'b000, exp_cts});
            chk("R6/R7 dcd", {3'b000, dcd_n_o}, {3'b000, exp_dcd});
            chk("R8 lock", {3'b000, lock_o}, {3'b000, m[0]});
        end

        // R10: latency of three edges
        diag_i = 2'b00;
        dtr_n_i = 1'b0;
        rts_n_i = 1'b0;
        lock_i = 1'b0;
        settle();
        lock_i = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 early", {cts_n_o, dcd_n_o, lock_o, 1'b0}, 4'b1100);
        @(negedge clk);
        chk("R10 due", {cts_n_o, dcd_n_o, lock_o, 1'b0}, 4'b0010);

        // R8: lock indicator in data mode with loopback
        hs_mode_i = 1'b0;
        diag_i = 2'b01;
        lock_i = 1'b0;
        settle();
        chk("R8 data", {3'b000, lock_o}, 4'b0000);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule